// File: doc/BRIEF.md
# PWM generator with queued duty samples

This block is a pulse-width modulator that software controls through four 32-bit registers on a plain read/write strobe interface. An input-clock prescaler produces a slower counter tick. A period counter advances once per tick and wraps after the programmed period plus two ticks. A single output pin goes high at the start of every period and drops when the counter reaches the current duty value.

Duty values are not written straight to the compare logic. Software queues them in a four-entry sample queue and can read the queue's fill level. The engine takes the next entry only at a period boundary, so a stream of duty values is applied one per period without glitches. When the queue runs dry, the last value stays in use.

A self-clearing soft-reset command lets software return the whole block to its idle state and discard any queued samples. Software can then confirm completion by polling the command bit.

Top module: `pwm_fifo_top`

## Requirements
- R1: After rst_n is released, every register reads 0 and pwm_out is low.
- R2: Register offsets are: control 0x00, status 0x04, sample 0x0C, period 0x10; other offsets read 0. In control, bit 0 is the run enable, bits 15:4 the prescaler value, bits 17:16 a stored source-select field, and bits 22, 23, 24 three stored mode flags. Bit 3 reads 1 only while a soft reset is in progress, and all other bits read 0. A read returns data in rdata on the clock edge that samples rd_en.
- R3: A write to the period register stores 0xFFFE when the 32-bit write value is 0xFFFE or more, and otherwise stores its low 16 bits. It reads back the stored value.
- R4: While enabled, one output period lasts (prescaler+1)*(period+2) input clocks.
- R5: pwm_out is high for the first min(duty, period+2)*(prescaler+1) input clocks of each period and low for the rest.
- R6: A duty sample of 0 keeps pwm_out constantly low.
- R7: A write to the sample register pushes wdata[15:0] into a 4-entry queue. Status bits 2:0 give the number of queued entries.
- R8: A sample write while the queue holds 4 entries is discarded. The occupancy stays 4, and the value never appears on the output.
- R9: An entry leaves the queue only at a period boundary or in the first cycle after enable. With an empty queue the last duty stays in use. The sample register reads the duty in use.
- R10: Clearing the enable bit drives pwm_out low from the write edge on and resets the counters. A later enable starts a fresh full period.
- R11: Writing control with bit 3 set starts a soft reset that lasts RST_CYCLES clocks and ignores the other bits of that write. The reset clears all registers, the duty in use and the output, and it empties the queue. Bit 3 reads 1 during the reset and 0 after it, and writes made during the reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered on the read edge |
| pwm_out | output | 1 | Modulated output |

## Verification
A register write takes effect on the edge that samples wr_en. The read data of a later read appears one edge after rd_en, so the bench drives strobes at the falling edge and samples rdata at the next falling edge. After an enable write, the first duty is loaded on the following edge, and pwm_out rises one cycle after the write. The bench therefore waits for a rising output, skips or counts whole periods, and measures high and low widths in input clocks against the formulas of R4 and R5. A cleared enable is observed at the falling edge right after the write edge. Soft-reset completion is polled through bit 3 rather than assumed at a fixed cycle.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;

  // register interface geometry
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 12;

  // byte offsets decoded by the register block
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_SAMP = 'h0C;
  localparam int OFS_PER  = 'h10;

  // control word bit positions
  localparam int BIT_RUN  = 0;
  localparam int BIT_SRST = 3;
  localparam int BIT_PRE  = 4;
  localparam int BIT_SEL  = 16;
  localparam int BIT_DBG  = 22;
  localparam int BIT_WAIT = 23;
  localparam int BIT_DOZE = 24;

  // largest period value the counter accepts
  localparam logic [CNT_W-1:0] PER_CEIL = {{(CNT_W-1){1'b1}}, 1'b0};

  typedef struct packed {
    logic             fl_doze;
    logic             fl_wait;
    logic             fl_dbg;
    logic [1:0]       src_sel;
    logic [PRE_W-1:0] presc;
    logic             run;
  } ctrl_t;

  // control readback word; busy shows the soft reset in progress
  function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c, logic busy);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_RUN]            = c.run;
    w[BIT_SRST]           = busy;
    w[BIT_PRE +: PRE_W]   = c.presc;
    w[BIT_SEL +: 2]       = c.src_sel;
    w[BIT_DBG]            = c.fl_dbg;
    w[BIT_WAIT]           = c.fl_wait;
    w[BIT_DOZE]           = c.fl_doze;
    return w;
  endfunction

  // saturate a written period value to the counter ceiling
  function automatic logic [CNT_W-1:0] period_sat(logic [DATA_W-1:0] w);
    if (w >= DATA_W'(PER_CEIL)) return PER_CEIL;
    return w[CNT_W-1:0];
  endfunction

  // last counter value of a period: a period spans value+2 ticks
  function automatic logic [CNT_W-1:0] period_last(logic [CNT_W-1:0] p);
    return p + 1'b1;
  endfunction

endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= ptr_next(wp);
      if (do_pop)  rp <= ptr_next(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/pwm_wave_engine.sv
module pwm_wave_engine
  import pwm_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [PRE_W-1:0] presc,
  input  logic [CNT_W-1:0] per_q,
  input  logic             fifo_empty,
  input  logic [CNT_W-1:0] fifo_head,
  output logic             pop,
  output logic [CNT_W-1:0] active,
  output logic             tick,
  output logic             boundary,
  output logic             pwm
);

  logic             run_q;
  logic [PRE_W-1:0] pcnt;
  logic [CNT_W-1:0] cnt;
  logic             start, wrap;

  assign tick     = run_q && (pcnt == presc);
  assign wrap     = tick && (cnt == period_last(per_q));
  assign start    = en && !run_q;
  assign boundary = start || wrap;
  assign pop      = boundary && !fifo_empty;
  assign pwm      = en && run_q && (cnt < active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pcnt   <= '0;
      cnt    <= '0;
      active <= '0;
    end else if (clr) begin
      run_q  <= 1'b0;
      pcnt   <= '0;
      cnt    <= '0;
      active <= '0;
    end else begin
      if (!en) begin
        run_q <= 1'b0;
        pcnt  <= '0;
        cnt   <= '0;
      end else begin
        run_q <= 1'b1;
        if (start) begin
          pcnt <= '0;
          cnt  <= '0;
        end else begin
          pcnt <= tick ? '0 : pcnt + 1'b1;
          if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
        end
      end
      if (pop) active <= fifo_head;
    end
  end

endmodule

// File: rtl/pwm_fifo_regs.sv
module pwm_fifo_regs
  import pwm_fifo_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int CW         = 3,
  parameter int RST_CYCLES = 4,
  localparam int RCW       = $clog2(RST_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CW-1:0]     fifo_count,
  input  logic [CNT_W-1:0]  active,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  per_q,
  output logic              push,
  output logic [CNT_W-1:0]  push_data,
  output logic              busy
);

  logic [RCW-1:0]    rst_cnt;
  logic              hit_ctrl, hit_stat, hit_samp, hit_per;
  ctrl_t             ctrl_wr;
  logic [DATA_W-1:0] rd_mux;

  assign hit_ctrl  = (int'(addr) == OFS_CTRL);
  assign hit_stat  = (int'(addr) == OFS_STAT);
  assign hit_samp  = (int'(addr) == OFS_SAMP);
  assign hit_per   = (int'(addr) == OFS_PER);
  assign busy      = (rst_cnt != '0);
  assign push      = wr_en && !busy && hit_samp;
  assign push_data = wdata[CNT_W-1:0];

  always_comb begin
    ctrl_wr.run     = wdata[BIT_RUN];
    ctrl_wr.presc   = wdata[BIT_PRE +: PRE_W];
    ctrl_wr.src_sel = wdata[BIT_SEL +: 2];
    ctrl_wr.fl_dbg  = wdata[BIT_DBG];
    ctrl_wr.fl_wait = wdata[BIT_WAIT];
    ctrl_wr.fl_doze = wdata[BIT_DOZE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      per_q   <= '0;
      rst_cnt <= '0;
    end else if (busy) begin
      ctrl_q  <= '0;
      per_q   <= '0;
      rst_cnt <= rst_cnt - 1'b1;
    end else if (wr_en) begin
      if (hit_ctrl) begin
        if (wdata[BIT_SRST]) begin
          ctrl_q  <= '0;
          per_q   <= '0;
          rst_cnt <= RCW'(RST_CYCLES);
        end else begin
          ctrl_q  <= ctrl_wr;
        end
      end
      if (hit_per) per_q <= period_sat(wdata);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)      rd_mux = ctrl_pack(ctrl_q, busy);
    else if (hit_stat) rd_mux = DATA_W'(fifo_count);
    else if (hit_samp) rd_mux = DATA_W'(active);
    else if (hit_per)  rd_mux = DATA_W'(per_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/pwm_fifo_top.sv
module pwm_fifo_top
  import pwm_fifo_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int FIFO_DEPTH = 4,
  parameter int RST_CYCLES = 4,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              pwm_out
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] per_q;
  logic             push_req;
  logic [CNT_W-1:0] push_data;
  logic             srst_busy;
  logic             fifo_pop;
  logic [CNT_W-1:0] fifo_head;
  logic [CW-1:0]    fifo_count;
  logic             fifo_full, fifo_empty;
  logic [CNT_W-1:0] active_duty;
  logic             cnt_tick;
  logic             load_evt;

  pwm_fifo_regs #(
    .ADDR_W(ADDR_W), .CW(CW), .RST_CYCLES(RST_CYCLES)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .fifo_count(fifo_count),
    .active(active_duty), .rdata(rdata), .ctrl_q(ctrl_q),
    .per_q(per_q), .push(push_req), .push_data(push_data),
    .busy(srst_busy)
  );

  pwm_sample_fifo #(
    .DEPTH(FIFO_DEPTH), .W(CNT_W)
  ) fifo_i (
    .clk(clk), .rst_n(rst_n), .clr(srst_busy), .push(push_req),
    .push_data(push_data), .pop(fifo_pop), .head(fifo_head),
    .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  pwm_wave_engine eng_i (
    .clk(clk), .rst_n(rst_n), .clr(srst_busy), .en(ctrl_q.run),
    .presc(ctrl_q.presc), .per_q(per_q), .fifo_empty(fifo_empty),
    .fifo_head(fifo_head), .pop(fifo_pop), .active(active_duty),
    .tick(cnt_tick), .boundary(load_evt), .pwm(pwm_out)
  );

endmodule

// File: rtl/pwm_fifo_chk.sv
module pwm_fifo_chk #(
  parameter int DEPTH      = 4,
  parameter int RST_CYCLES = 4,
  parameter int CW         = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] fifo_count,
  input logic          fifo_full,
  input logic          fifo_pop,
  input logic          push_req,
  input logic          load_evt,
  input logic          srst_busy,
  input logic          run_en,
  input logic [15:0]   active_duty,
  input logic [15:0]   per_q,
  input logic          pwm_out
);

  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_run <= 0;
    else if (srst_busy) busy_run <= busy_run + 1;
    else                busy_run <= 0;
  end

  // R7
  fifo_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_count) <= DEPTH);

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && fifo_full && !fifo_pop) |=> (int'(fifo_count) == DEPTH));

  // R9
  pop_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !srst_busy) |=> (fifo_count >= $past(fifo_count)));

  // R6
  zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_duty == 16'd0) |-> !pwm_out);

  // R10
  disable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !pwm_out);

  // R3
  period_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_q <= 16'hFFFE);

  // R11
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |=> (fifo_count == '0 && active_duty == 16'd0));

  // R11
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= RST_CYCLES);

endmodule

bind pwm_fifo_top pwm_fifo_chk #(
  .DEPTH(FIFO_DEPTH), .RST_CYCLES(RST_CYCLES), .CW(CW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count), .fifo_full(fifo_full),
  .fifo_pop(fifo_pop), .push_req(push_req), .load_evt(load_evt),
  .srst_busy(srst_busy), .run_en(ctrl_q.run), .active_duty(active_duty),
  .per_q(per_q), .pwm_out(pwm_out)
);

// File: tb/pwm_fifo_top_tb_top.sv
`timescale 1ns/1ps
module pwm_fifo_top_tb_top;

  localparam int A_CTRL = 'h00;
  localparam int A_STAT = 'h04;
  localparam int A_SAMP = 'h0C;
  localparam int A_PER  = 'h10;
  localparam int LIM    = 2000;

  // prescaler, period, duty, expected high clocks, expected period clocks
  localparam int NV = 5;
  localparam int TBL [NV][5] = '{
    '{0, 3, 2, 2, 5},
    '{2, 4, 3, 9, 18},
    '{1, 0, 1, 2, 4},
    '{0, 6, 7, 7, 8},
    '{3, 2, 1, 4, 16}
  };

  logic        clk = 1'b0;
  logic        rst_n, wr_en, rd_en;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        pwm_out;
  int          nchk = 0;
  int          nerr = 0;

  always #4 clk = ~clk;

  pwm_fifo_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  task automatic check(string tag, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    addr  = 5'(a);
    wdata = d;
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr  = 5'(a);
    rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_srst();
    logic [31:0] v;
    wr(A_CTRL, 32'h8);
    rd(A_CTRL, v);
    check("R11 reset bit set", longint'(v[3]), 1);
    for (int k = 0; k < 20; k++) begin
      rd(A_CTRL, v);
      if (!v[3]) break;
    end
    check("R11 reset bit self-clears", longint'(v[3]), 0);
  endtask

  task automatic wait_rise();
    logic prev;
    prev = pwm_out;
    for (int k = 0; k < LIM; k++) begin
      @(negedge clk);
      if (!prev && pwm_out) return;
      prev = pwm_out;
    end
  endtask

  // starts on the first high sample of a period, ends on the next one
  task automatic meas(output int hi, output int lo);
    hi = 0;
    lo = 0;
    while (pwm_out === 1'b1 && hi < LIM) begin hi++; @(negedge clk); end
    while (pwm_out === 1'b0 && lo < LIM) begin lo++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog all-reqs actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int hi, lo, highs;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (5) @(negedge clk);
    check("R1 output low in reset", longint'(pwm_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state of every register
    rd(A_CTRL, v); check("R1 control", v, 0);
    rd(A_STAT, v); check("R1 status", v, 0);
    rd(A_SAMP, v); check("R1 sample", v, 0);
    rd(A_PER,  v); check("R1 period", v, 0);

    // R2 stored control fields and reserved bits
    wr(A_CTRL, 32'h01C2_0AB0);
    rd(A_CTRL, v); check("R2 control fields", v, 32'h01C2_0AB0);
    wr(A_CTRL, 32'hFFFF_FFF6);
    rd(A_CTRL, v); check("R2 reserved bits read 0", v, 32'h01C3_FFF0);
    rd('h08, v);   check("R2 unmapped offset", v, 0);
    check("R2 output stays low", longint'(pwm_out), 0);

    // R3 period saturation
    wr(A_PER, 32'h0000_FFFF); rd(A_PER, v); check("R3 0xFFFF", v, 32'hFFFE);
    wr(A_PER, 32'h0001_0005); rd(A_PER, v); check("R3 above 16 bits", v, 32'hFFFE);
    wr(A_PER, 32'h0000_FFFE); rd(A_PER, v); check("R3 at ceiling", v, 32'hFFFE);
    wr(A_PER, 32'h0000_1234); rd(A_PER, v); check("R3 plain value", v, 32'h1234);

    // R11 soft reset clears state, ignores other bits and busy-time writes
    wr(A_SAMP, 32'd5);
    wr(A_SAMP, 32'd6);
    rd(A_STAT, v); check("R7 two queued", v, 2);
    wr(A_CTRL, 32'h0000_0AB9);
    wr(A_PER, 32'h55);
    wr(A_SAMP, 32'd7);
    for (int k = 0; k < 20; k++) begin
      rd(A_CTRL, v);
      if (!v[3]) break;
    end
    check("R11 control cleared", v, 0);
    rd(A_STAT, v); check("R11 queue flushed", v, 0);
    rd(A_PER, v);  check("R11 period cleared, busy write ignored", v, 0);
    check("R11 output low", longint'(pwm_out), 0);

    // R4 R5 table of prescaler, period and duty settings
    for (int i = 0; i < NV; i++) begin
      do_srst();
      wr(A_PER, 32'(TBL[i][1]));
      wr(A_SAMP, 32'(TBL[i][2]));
      wr(A_CTRL, 32'((TBL[i][0] << 4) | 1));
      wait_rise();
      meas(hi, lo);
      meas(hi, lo);
      check($sformatf("R5 high width vec%0d", i), hi, TBL[i][3]);
      check($sformatf("R4 period width vec%0d", i), hi + lo, TBL[i][4]);
    end

    // R7 R8 R9 queue occupancy, full drop, boundary pops, last kept
    do_srst();
    wr(A_PER, 32'd8);
    for (int k = 1; k <= 4; k++) begin
      wr(A_SAMP, 32'(k));
      rd(A_STAT, v);
      check($sformatf("R7 occupancy %0d", k), v, k);
    end
    wr(A_SAMP, 32'd9);
    rd(A_STAT, v); check("R8 full write dropped", v, 4);
    wr(A_CTRL, 32'h1);
    wait_rise();
    for (int k = 1; k <= 5; k++) begin
      meas(hi, lo);
      check($sformatf("R9 period %0d duty", k), hi, (k > 4) ? 4 : k);
      if (k == 2) check("R4 period with queue", hi + lo, 10);
    end
    rd(A_SAMP, v); check("R9 last duty kept", v, 4);
    rd(A_STAT, v); check("R9 queue drained", v, 0);

    // R6 duty of zero keeps the output low
    do_srst();
    wr(A_PER, 32'd3);
    wr(A_SAMP, 32'd0);
    wr(A_CTRL, 32'h1);
    highs = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (pwm_out) highs++;
    end
    check("R6 zero duty never high", highs, 0);

    // R10 disable mid-period, then a fresh period on re-enable
    do_srst();
    wr(A_PER, 32'd5);
    wr(A_SAMP, 32'd4);
    wr(A_CTRL, 32'h1);
    wait_rise();
    meas(hi, lo);
    @(negedge clk);
    wr(A_CTRL, 32'h0);
    check("R10 low right after disable", longint'(pwm_out), 0);
    highs = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pwm_out) highs++;
    end
    check("R10 stays low while disabled", highs, 0);
    wr(A_CTRL, 32'h1);
    wait_rise();
    meas(hi, lo);
    check("R10 fresh first high", hi, 4);
    check("R10 fresh first period", hi + lo, 7);

    summary();
    $finish;
  end

endmodule